// File: doc/BRIEF.md
# Sixteen-Pin GPIO Register Bank

This block holds the register state behind a sixteen-pin general purpose I/O expander. The pins are grouped into two ports of eight. Each port has four register kinds: a sampled input view, an output value, a per-bit read inversion mask and a direction mask. A simple register bus reaches all of them. It has an 8-bit address, a write strobe with write data, and a read strobe with registered read data. Toward the pads the block drives a value and an enable for each pin, and it takes in the raw pin level.

The raw pin levels are resynchronised by a two-flop chain before any read can see them. An input read returns the synchronised level XORed with that port's inversion mask. It reports the level on every pin, including pins the block is driving itself. A read of an output register returns the stored value, not the level on the pin. The input registers cannot be written. Addresses outside the eight defined ones read as zero and ignore writes.

Top module: `gpio16_regbank`

## Requirements
- R1: After reset the output and direction registers of both ports are 0xFF and the inversion registers are 0x00. pin_oe and pin_out are all zero and reg_rdata is 0x00.
- R2: Address decode for 0x00 to 0x07: bit 0 selects the port (0 = pins 7:0, 1 = pins 15:8). Bits 2:1 select the kind: 0 input, 1 output, 2 inversion, 3 direction.
- R3: A write strobe at an output, inversion or direction address stores reg_wdata into that one register at the clock edge. All other registers keep their values.
- R4: Each pin_oe bit is the inverse of its direction bit (1 = input, 0 = output). Each pin_out bit equals the output register bit while the pin is an output and is 0 while it is an input.
- R5: A read of an output, inversion or direction register returns the stored byte, whatever level the pins have.
- R6: A read of an input register returns the synchronised pin level XOR the port's inversion mask. This holds for pins set as inputs and for pins set as outputs.
- R7: A pin level presented before clock edge k is first seen by a read strobe sampled at edge k+2. Strobes at edges k and k+1 still return the previous level.
- R8: Writes to addresses 0x00 and 0x01 change no register and do not alter later input reads.
- R9: A read of any address from 0x08 to 0xFF returns 0x00, and a write there is discarded.
- R10: reg_rdata is loaded at the clock edge where reg_rd_en is high and otherwise holds its value. A read and a write to the same address in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_out | output | 16 | Pin drive value |
| pin_oe | output | 16 | Pin drive enable, 1 = drive |

## Verification
reg_rdata is due at the edge that samples the read strobe, one cycle after it is issued. Register writes reach pin_oe and pin_out at the edge that samples the write strobe. A new pin level reaches reads only two edges after it is applied. The bench drives all inputs on the falling edge. Its behavioural model updates on the rising edge with the same pipeline depths, and outputs are compared on the next falling edge, so every result is checked in the cycle it is due. Directed checks of the synchroniser delay read on three consecutive edges after a pin change, to pin down exactly which edge exposes the new level.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
    typedef enum logic [1:0] {
        KIND_INPUT  = 2'd0,
        KIND_OUTPUT = 2'd1,
        KIND_INVERT = 2'd2,
        KIND_DIR    = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = raw_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> chain_q[STAGES-1] == $past(chain_q[STAGES-2])); // R7
        end
    endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic              wr_inv,
    input  logic              wr_dir,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] inv_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] drv_val,
    output logic [PORT_W-1:0] drv_en
);
    typedef struct packed {
        logic [PORT_W-1:0] outv;
        logic [PORT_W-1:0] inv;
        logic [PORT_W-1:0] dir;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_out) st_d.outv = wdata;
        if (wr_inv) st_d.inv  = wdata;
        if (wr_dir) st_d.dir  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.outv <= '1;
            st_q.inv  <= '0;
            st_q.dir  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q   = st_q.outv;
    assign inv_q   = st_q.inv;
    assign dir_q   = st_q.dir;
    assign drv_en  = ~st_q.dir;
    assign drv_val = st_q.outv & ~st_q.dir;

    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> out_q == $past(wdata)); // R3
    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_inv |=> $stable(inv_q)); // R3
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q)); // R3
endmodule

// File: rtl/gpio16_regbank.sv
module gpio16_regbank
    import gpio16_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr_en,
    input  logic [PORT_W-1:0]             reg_wdata,
    input  logic                          reg_rd_en,
    output logic [PORT_W-1:0]             reg_rdata,
    input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
    output logic [PORT_W*NUM_PORTS-1:0]   pin_out,
    output logic [PORT_W*NUM_PORTS-1:0]   pin_oe
);
    localparam int PINS  = PORT_W * NUM_PORTS;
    localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int DEC_W = SEL_W + 2;

    typedef struct packed {
        logic [PORT_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    logic [PINS-1:0]                  pin_sync;
    logic [NUM_PORTS-1:0][PORT_W-1:0] out_arr, inv_arr, dir_arr, in_arr;
    logic                             addr_hit;
    logic                             port_ok;
    logic [SEL_W-1:0]                 port_sel;
    reg_kind_e                        kind;

    gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    always_comb begin
        addr_hit = ((reg_addr >> DEC_W) == '0);
        port_sel = reg_addr[SEL_W-1:0];
        kind     = reg_kind_e'(reg_addr[DEC_W-1:SEL_W]);
        port_ok  = addr_hit && (int'(port_sel) < NUM_PORTS);
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic sel;
            assign sel = reg_wr_en && port_ok && (port_sel == SEL_W'(p));
            assign in_arr[p] = pin_sync[p*PORT_W +: PORT_W];

            gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_out  (sel && kind == KIND_OUTPUT),
                .wr_inv  (sel && kind == KIND_INVERT),
                .wr_dir  (sel && kind == KIND_DIR),
                .wdata   (reg_wdata),
                .out_q   (out_arr[p]),
                .inv_q   (inv_arr[p]),
                .dir_q   (dir_arr[p]),
                .drv_val (pin_out[p*PORT_W +: PORT_W]),
                .drv_en  (pin_oe[p*PORT_W +: PORT_W])
            );
        end
    endgenerate

    always_comb begin
        rd_d = rd_q;
        if (reg_rd_en) begin
            rd_d.rdata = '0;
            if (port_ok) begin
                case (kind)
                    KIND_INPUT:  rd_d.rdata = in_arr[port_sel] ^ inv_arr[port_sel];
                    KIND_OUTPUT: rd_d.rdata = out_arr[port_sel];
                    KIND_INVERT: rd_d.rdata = inv_arr[port_sel];
                    default:     rd_d.rdata = dir_arr[port_sel];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !addr_hit) |=> reg_rdata == '0); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata)); // R10
    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && addr_hit && kind == KIND_INPUT)
        |=> ($stable(out_arr) && $stable(inv_arr) && $stable(dir_arr))); // R8
    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !addr_hit)
        |=> ($stable(out_arr) && $stable(inv_arr) && $stable(dir_arr))); // R9
endmodule

// File: tb/gpio16_regbank_tb.sv
module gpio16_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit model_on = 1'b0;

    // behavioural reference state
    logic [15:0] m_out = 16'hFFFF, m_inv = '0, m_dir = 16'hFFFF;
    logic [15:0] m_s1 = '0, m_s2 = '0;
    logic [7:0]  m_rd = '0;
    string       m_tag = "R1";

    always #5 clk = ~clk;

    gpio16_regbank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rd_en (reg_rd_en),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic expect_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        int sh;
        if (a >= 8'h08) return 8'h00;
        sh = a[0] ? 8 : 0;
        case (a[2:1])
            2'd0:    return 8'((m_s2 ^ m_inv) >> sh);
            2'd1:    return 8'(m_out >> sh);
            2'd2:    return 8'(m_inv >> sh);
            default: return 8'(m_dir >> sh);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 16'hFFFF; m_inv = '0; m_dir = 16'hFFFF;
            m_s1 = '0; m_s2 = '0; m_rd = '0; m_tag = "R1";
        end else begin
            if (reg_rd_en) begin
                m_rd = model_read(reg_addr);
                if (reg_addr >= 8'h08)        m_tag = "R9";
                else if (reg_addr[2:1] == 0)  m_tag = "R6";
                else                          m_tag = "R5";
            end
            if (reg_wr_en && reg_addr < 8'h08) begin
                case (reg_addr[2:1])
                    2'd1: if (reg_addr[0]) m_out[15:8] = reg_wdata; else m_out[7:0] = reg_wdata;
                    2'd2: if (reg_addr[0]) m_inv[15:8] = reg_wdata; else m_inv[7:0] = reg_wdata;
                    2'd3: if (reg_addr[0]) m_dir[15:8] = reg_wdata; else m_dir[7:0] = reg_wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (model_on && !done) begin
            expect_eq({m_tag, " model rdata"}, {8'h00, reg_rdata}, {8'h00, m_rd});
            expect_eq("R4 model pin_oe", pin_oe, ~m_dir);
            expect_eq("R4 model pin_out", pin_out, m_out & ~m_dir);
        end
    end

    task automatic access(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wr_en = wr;
        reg_rd_en = rd;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        access(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        access(1'b0, 1'b1, a, 8'h00);
        expect_eq(tag, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        model_on = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_eq("R1 pin_oe", pin_oe, 16'h0000);
        expect_eq("R1 pin_out", pin_out, 16'h0000);
        expect_eq("R1 rdata", {8'h00, reg_rdata}, 16'h0000);
        rd_chk("R1 out0", 8'h02, 8'hFF);
        rd_chk("R1 out1", 8'h03, 8'hFF);
        rd_chk("R1 inv0", 8'h04, 8'h00);
        rd_chk("R1 inv1", 8'h05, 8'h00);
        rd_chk("R1 dir0", 8'h06, 8'hFF);
        rd_chk("R1 dir1", 8'h07, 8'hFF);

        // R2 / R6 port order of input reads
        pin_in = 16'hA55A;
        repeat (3) @(negedge clk);
        rd_chk("R2 R6 input port0", 8'h00, 8'h5A);
        rd_chk("R2 R6 input port1", 8'h01, 8'hA5);

        // R7 two-edge sampling delay
        pin_in = 16'h00FF;
        rd_chk("R7 edge k old", 8'h00, 8'h5A);
        rd_chk("R7 edge k+1 old", 8'h00, 8'h5A);
        rd_chk("R7 edge k+2 new", 8'h00, 8'hFF);

        // R6 inversion
        wr(8'h04, 8'h0F);
        rd_chk("R6 inverted port0", 8'h00, 8'hF0);
        wr(8'h05, 8'hFF);
        rd_chk("R6 inverted port1", 8'h01, 8'hFF);

        // R3 / R4 / R5 output and direction
        wr(8'h02, 8'h3C);
        rd_chk("R3 R5 out0 stored", 8'h02, 8'h3C);
        expect_eq("R4 inputs not driven oe", pin_oe, 16'h0000);
        expect_eq("R4 inputs not driven out", pin_out, 16'h0000);
        wr(8'h06, 8'hF0);
        expect_eq("R4 oe low nibble", pin_oe, 16'h000F);
        expect_eq("R4 out low nibble", pin_out, 16'h000C);
        rd_chk("R6 input sees driven pins", 8'h00, 8'hF0);
        rd_chk("R5 out0 not pin level", 8'h02, 8'h3C);
        wr(8'h07, 8'h00);
        wr(8'h03, 8'h81);
        expect_eq("R4 oe both ports", pin_oe, 16'hFF0F);
        expect_eq("R4 out both ports", pin_out, 16'h810C);
        rd_chk("R3 dir0 untouched", 8'h06, 8'hF0);

        // R8 writes to input addresses ignored
        wr(8'h00, 8'h00);
        wr(8'h01, 8'h00);
        rd_chk("R8 out0", 8'h02, 8'h3C);
        rd_chk("R8 out1", 8'h03, 8'h81);
        rd_chk("R8 inv0", 8'h04, 8'h0F);
        rd_chk("R8 inv1", 8'h05, 8'hFF);
        rd_chk("R8 dir0", 8'h06, 8'hF0);
        rd_chk("R8 dir1", 8'h07, 8'h00);
        rd_chk("R8 input0 still pins", 8'h00, 8'hF0);

        // R9 unmapped addresses
        wr(8'h08, 8'h55);
        wr(8'h0A, 8'h55);
        wr(8'hFF, 8'h55);
        rd_chk("R9 read 0x08", 8'h08, 8'h00);
        rd_chk("R9 read 0x0A", 8'h0A, 8'h00);
        rd_chk("R9 read 0xFF", 8'hFF, 8'h00);
        rd_chk("R9 out0 unchanged", 8'h02, 8'h3C);
        rd_chk("R9 out1 unchanged", 8'h03, 8'h81);
        expect_eq("R9 pins unchanged", pin_out, 16'h810C);

        // R10 read-during-write and hold
        access(1'b1, 1'b1, 8'h02, 8'h99);
        expect_eq("R10 read before write", {8'h00, reg_rdata}, 16'h003C);
        repeat (3) @(negedge clk);
        expect_eq("R10 rdata holds", {8'h00, reg_rdata}, 16'h003C);
        rd_chk("R10 new value", 8'h02, 8'h99);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule